// File: doc/BRIEF.md
# Serial EEPROM Slave Controller

This block is the device side of a byte-wide serial EEPROM, in synthesizable logic. A master drives a chip select, a serial clock, a serial data line and a pause line. The block answers on a serial output with a separate output-enable pin, so the output can be tri-stated at the pad. All four inputs are brought into a faster system clock through two-flop synchronizers, and their edges are detected in that clock domain. The serial clock may idle low (mode 0) or high (mode 3). Input bits are taken on rising serial-clock edges, and output bits change on falling edges.

Each select carries one 8-bit instruction: set or clear the write-enable latch, read or write the status byte, or read or write the array. A read streams bytes from a 16-bit start address for as long as the clock runs, and wraps from the top of the array to zero. A write collects data bytes into a page buffer whose index wraps inside one page. When the select rises on a whole byte, the write is committed by a self-timed write cycle that lasts a parameterised number of system clocks. During that cycle only a status read is answered.

The serial pins have no valid/ready handshake; the master paces every transfer with its clock. There is therefore no back-pressure. Instead, the master must keep each serial-clock phase at least five system clocks long.

Top module: `eeprom_spi_slave`

## Requirements
- R1: The six instruction bytes are 0x06 (set write-enable latch), 0x04 (clear it), 0x05 (status read), 0x01 (status write), 0x03 (array read) and 0x02 (array write). Any other first byte is ignored, and `spi_so_oe` stays low until the select ends.
- R2: Input bits are sampled on rising serial-clock edges and output bits change on falling edges, MSB first, in both mode 0 (clock idles low) and mode 3 (clock idles high).
- R3: A 16-bit address, MSB first, follows instruction 0x03 or 0x02. Only its low ADDR_W bits select a byte; the upper bits are ignored.
- R4: In a write, the buffer index advances only in its low PAGE_W bits. Loading past the end of a page wraps to the first byte of the same page, and the later byte replaces the earlier one.
- R5: In a read, the address advances after every byte, wraps from 2^ADDR_W-1 to 0, and keeps streaming until the select rises.
- R6: A write (array or status) is committed only when the select rises on a whole-byte boundary with at least one data byte received. A partial last byte, or no data byte at all, aborts the write: memory is untouched, no write cycle starts, and the write-enable latch keeps its value.
- R7: A committed write starts a write cycle of WR_CYCLES system clocks with status bit 0 at 1. During the cycle every instruction except 0x05 is ignored, and the output stays disabled.
- R8: Instruction 0x06 sets the write-enable latch (status bit 1) only if the select rises right after its 8th bit; any further clock cancels it. Instruction 0x04 clears the latch. Array and status writes are ignored while the latch is 0.
- R9: The write-enable latch clears by itself when a write cycle ends.
- R10: While the select is high, `spi_so_oe` is low and all transfer state is reset; each transfer starts at a select fall.
- R11: While the pause input is low during a select, serial-clock edges and data input are ignored and `spi_so_oe` is low. The transfer resumes where it stopped once the pause input returns high.
- R12: The status byte holds bit 0 = write cycle in progress and bit 1 = write-enable latch. Bits 7, 6, 4, 3 and 2 are set by a status write. Bit 5 always reads 0. After reset the status byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low select |
| spi_si | input | 1 | Serial data into the block |
| spi_hold_n | input | 1 | Active-low pause of the current transfer |
| spi_so | output | 1 | Serial data out of the block |
| spi_so_oe | output | 1 | High when `spi_so` should be driven onto the pad |

## Verification
The bench builds the block with ADDR_W=9, PAGE_W=5 and WR_CYCLES=400. With these values the whole 512-byte array can be filled page by page and read back in one sweep, and the read can be started near the top of the array to show the wrap to zero. The 32-byte page is small enough to overflow in a single transfer. The 400-clock write cycle is long enough that a complete status read and a rejected array read both fall inside it.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    PH_OPC, PH_ADDR, PH_WDATA, PH_SWR, PH_RDATA, PH_SRD, PH_DONE, PH_IGNORE
  } phase_e;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  // status bits [7:2] a status write may change (bit 5 stays zero)
  localparam logic [7:2] ST_WR_MASK = 6'b110111;
endpackage

// File: rtl/eep_in_sync.sv
module eep_in_sync #(
  parameter int N = 4,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] lvl
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {2{RST_VAL[g]}};
      else        pipe <= {pipe[0], async_in[g]};
    end
    assign lvl[g] = pipe[1];
  end
endmodule

// File: rtl/eep_wr_timer.sv
module eep_wr_timer #(
  parameter int CYCLES = 250000,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              last,
  output logic              copy_act,
  output logic [PAGE_W-1:0] copy_idx
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam logic [CW-1:0] LAST_CNT = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == LAST_CNT) busy <= 1'b0;
      else                 cnt  <= cnt + 1'b1;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end
  end

  assign last     = busy && (cnt == LAST_CNT);
  assign copy_act = busy && (32'(cnt) < PAGE_BYTES);
  assign copy_idx = cnt[PAGE_W-1:0];

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (cnt != LAST_CNT) |=> busy);

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> cnt == '0);
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [PAGE_W-1:0] rd_idx,
  output logic [7:0]        rd_data,
  output logic              rd_valid
);
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [7:0]            pg_mem [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld;

  always_ff @(posedge clk) begin
    if (wr_en) pg_mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vld <= '0;
    else if (clr)   vld <= '0;
    else if (wr_en) vld[wr_idx] <= 1'b1;
  end

  assign rd_data  = pg_mem[rd_idx];
  assign rd_valid = vld[rd_idx];
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/eeprom_spi_slave.sv
module eeprom_spi_slave #(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 6,
  parameter int WR_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_si,
  input  logic spi_hold_n,
  output logic spi_so,
  output logic spi_so_oe
);
  import eep_pkg::*;

  localparam int HI_W  = ADDR_W - 8;
  localparam int PG_HI = ADDR_W - PAGE_W;

  // ---------------- input synchronisation and edge detect
  logic [3:0] raw_in, lvl;
  assign raw_in = {spi_hold_n, spi_si, spi_cs_n, spi_sck};

  eep_in_sync #(.N(4), .RST_VAL(4'b1010)) i_sync (
    .clk(clk), .rst_n(rst_n), .async_in(raw_in), .lvl(lvl)
  );

  logic sck_l, csn_l, si_l, hold_l, sck_d, csn_d;
  assign sck_l  = lvl[0];
  assign csn_l  = lvl[1];
  assign si_l   = lvl[2];
  assign hold_l = lvl[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      csn_d <= 1'b1;
    end else begin
      sck_d <= sck_l;
      csn_d <= csn_l;
    end
  end

  logic cs_act, cs_rise, cs_fall, hold_act, sck_r, sck_f;
  assign cs_act   = !csn_l;
  assign cs_rise  = csn_l && !csn_d;
  assign cs_fall  = !csn_l && csn_d;
  assign hold_act = cs_act && !hold_l;
  assign sck_r    = cs_act && !hold_act && sck_l && !sck_d;
  assign sck_f    = cs_act && !hold_act && !sck_l && sck_d;

  // ---------------- transfer state
  phase_e            phase;
  logic [2:0]        bitc, out_cnt;
  logic [6:0]        shreg;
  logic              abyte, rd_sel, extra_clk, got_data, out_act, so_q, wel;
  logic [HI_W-1:0]   addr_hi;
  logic [ADDR_W-1:0] rd_addr;
  logic [PG_HI-1:0]  page_base;
  logic [PAGE_W-1:0] wr_ptr;
  logic [7:2]        swr_q, st_nv;
  logic [7:0]        tx_byte;

  logic              busy, wr_last, copy_act, pb_valid, mem_we;
  logic [PAGE_W-1:0] copy_idx;
  logic [7:0]        pb_rdata, mem_rdata;

  logic [7:0]        byte_nxt, status_byte, out_src;
  logic [ADDR_W-1:0] addr_full;
  logic              byte_done, out_phase, wr_start, pb_we;

  assign byte_nxt    = {shreg, si_l};
  assign byte_done   = sck_r && (bitc == 3'd7);
  assign addr_full   = {addr_hi, byte_nxt};
  assign status_byte = {st_nv, wel, busy};
  assign out_phase   = (phase == PH_RDATA) || (phase == PH_SRD);
  assign out_src     = (phase == PH_RDATA) ? mem_rdata : status_byte;
  assign wr_start    = cs_rise && !busy && got_data && (bitc == 3'd0) &&
                       ((phase == PH_WDATA) || (phase == PH_SWR));
  assign pb_we       = byte_done && (phase == PH_WDATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_OPC;
      bitc      <= '0;
      out_cnt   <= '0;
      shreg     <= '0;
      abyte     <= 1'b0;
      rd_sel    <= 1'b0;
      extra_clk <= 1'b0;
      got_data  <= 1'b0;
      out_act   <= 1'b0;
      so_q      <= 1'b0;
      wel       <= 1'b0;
      addr_hi   <= '0;
      rd_addr   <= '0;
      page_base <= '0;
      wr_ptr    <= '0;
      swr_q     <= '0;
      st_nv     <= '0;
      tx_byte   <= '0;
    end else begin
      if (!cs_act) begin
        if (cs_rise && !busy) begin
          if (phase == PH_DONE && !extra_clk) wel <= 1'b1;
          if (wr_start && phase == PH_SWR) st_nv <= swr_q & ST_WR_MASK;
        end
        phase     <= PH_OPC;
        bitc      <= '0;
        out_cnt   <= '0;
        abyte     <= 1'b0;
        extra_clk <= 1'b0;
        got_data  <= 1'b0;
        out_act   <= 1'b0;
      end else begin
        if (sck_r) begin
          bitc  <= bitc + 1'b1;
          shreg <= byte_nxt[6:0];
          unique case (phase)
            PH_OPC: if (byte_done) begin
              if (busy && byte_nxt != OP_RDSR) phase <= PH_IGNORE;
              else begin
                unique case (byte_nxt)
                  OP_RDSR:  phase <= PH_SRD;
                  OP_WREN:  phase <= PH_DONE;
                  OP_WRDI:  begin wel <= 1'b0; phase <= PH_IGNORE; end
                  OP_WRSR:  phase <= wel ? PH_SWR : PH_IGNORE;
                  OP_READ:  begin rd_sel <= 1'b1; phase <= PH_ADDR; end
                  OP_WRITE: begin
                    rd_sel <= 1'b0;
                    phase  <= wel ? PH_ADDR : PH_IGNORE;
                  end
                  default:  phase <= PH_IGNORE;
                endcase
              end
            end
            PH_ADDR: if (byte_done) begin
              if (!abyte) begin
                addr_hi <= byte_nxt[HI_W-1:0];
                abyte   <= 1'b1;
              end else if (rd_sel) begin
                rd_addr <= addr_full;
                phase   <= PH_RDATA;
              end else begin
                page_base <= addr_full[ADDR_W-1:PAGE_W];
                wr_ptr    <= addr_full[PAGE_W-1:0];
                phase     <= PH_WDATA;
              end
            end
            PH_WDATA: if (byte_done) begin
              wr_ptr   <= wr_ptr + 1'b1;
              got_data <= 1'b1;
            end
            PH_SWR: if (byte_done) begin
              swr_q    <= byte_nxt[7:2];
              got_data <= 1'b1;
            end
            PH_DONE: extra_clk <= 1'b1;
            default: ;
          endcase
        end
        if (sck_f && out_phase) begin
          out_cnt <= out_cnt + 1'b1;
          if (out_cnt == 3'd0) begin
            tx_byte <= out_src;
            so_q    <= out_src[7];
            out_act <= 1'b1;
            if (phase == PH_RDATA) rd_addr <= rd_addr + 1'b1;
          end else begin
            so_q <= tx_byte[3'd7 - out_cnt];
          end
        end
      end
      if (wr_last) wel <= 1'b0;
    end
  end

  assign spi_so    = so_q;
  assign spi_so_oe = out_act && cs_act && !hold_act;

  // ---------------- write cycle, page buffer, array
  eep_wr_timer #(.CYCLES(WR_CYCLES), .PAGE_W(PAGE_W)) i_timer (
    .clk(clk), .rst_n(rst_n), .start(wr_start), .busy(busy),
    .last(wr_last), .copy_act(copy_act), .copy_idx(copy_idx)
  );

  eep_page_buf #(.PAGE_W(PAGE_W)) i_pbuf (
    .clk(clk), .rst_n(rst_n), .clr(cs_fall && !busy), .wr_en(pb_we),
    .wr_idx(wr_ptr), .wr_data(byte_nxt), .rd_idx(copy_idx),
    .rd_data(pb_rdata), .rd_valid(pb_valid)
  );

  // a status write leaves the buffer empty, so nothing is copied
  assign mem_we = copy_act && pb_valid;

  eep_array #(.ADDR_W(ADDR_W)) i_array (
    .clk(clk), .we(mem_we), .waddr({page_base, copy_idx}), .wdata(pb_rdata),
    .raddr(rd_addr), .rdata(mem_rdata)
  );

  // ---------------- assertions
  // R10
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !out_act && (phase == PH_OPC));

  // R11
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_act && $past(hold_act) |-> $stable(bitc) && $stable(out_cnt));

  // R6
  mem_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R9
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);

  // R8
  wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(cs_rise));

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && byte_done && (phase == PH_OPC) && (byte_nxt != OP_RDSR)
    |=> phase == PH_IGNORE);

  // R1
  invalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_IGNORE |-> !out_act);
endmodule

// File: tb/test_eeprom_spi_slave.sv
module test_eeprom_spi_slave;
  localparam int AW = 9;
  localparam int PW = 5;
  localparam int WC = 400;
  localparam int DEPTH = 1 << AW;
  localparam int PAGE = 1 << PW;
  localparam int HP = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_si = 1'b0, spi_hold_n = 1'b1;
  logic spi_so, spi_so_oe;

  always #10 clk = ~clk;

  eeprom_spi_slave #(.ADDR_W(AW), .PAGE_W(PW), .WR_CYCLES(WC)) i_eeprom_spi_slave (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_si(spi_si), .spi_hold_n(spi_hold_n), .spi_so(spi_so), .spi_so_oe(spi_so_oe)
  );

  int errors = 0, checks = 0;
  bit finished = 0;
  logic mode3 = 1'b0;
  logic [7:0] mdl [DEPTH];
  logic [7:0] wbuf [64];
  logic hold_oe;

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) ^ (a >> 5));
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic begin_x();
    spi_sck = mode3;
    tick(2);
    spi_cs_n = 1'b0;
    tick(HP);
  endtask

  task automatic end_x();
    if (!mode3) spi_sck = 1'b0;
    tick(HP);
    spi_cs_n = 1'b1;
    tick(2 * HP);
  endtask

  task automatic bit_x(input logic b, output logic r, output logic oe);
    spi_sck = 1'b0;
    spi_si = b;
    tick(HP);
    r = spi_so;
    oe = spi_so_oe;
    spi_sck = 1'b1;
    tick(HP);
  endtask

  task automatic send_byte(input logic [7:0] v);
    logic r, oe;
    for (int i = 7; i >= 0; i--) bit_x(v[i], r, oe);
  endtask

  task automatic do_hold();
    spi_sck = 1'b0;
    tick(HP);
    spi_hold_n = 1'b0;
    tick(6);
    hold_oe = spi_so_oe;
    spi_si = 1'b1;
    spi_sck = 1'b1;
    tick(3);
    spi_sck = 1'b0;
    spi_si = 1'b0;
    tick(4);
    spi_hold_n = 1'b1;
    tick(HP);
  endtask

  task automatic recv_byte(output logic [7:0] v, output logic all_oe, input int hold_at);
    logic r, oe;
    all_oe = 1'b1;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      if (i == hold_at) do_hold();
      bit_x(1'b0, r, oe);
      v = {v[6:0], r};
      all_oe &= oe;
    end
  endtask

  task automatic cmd(input logic [7:0] op);
    begin_x();
    send_byte(op);
    end_x();
  endtask

  task automatic rdsr(output logic [7:0] v);
    logic oe;
    begin_x();
    send_byte(8'h05);
    recv_byte(v, oe, -1);
    end_x();
  endtask

  task automatic write_mem(input logic [15:0] a, input int n, input int tail_bits);
    begin_x();
    send_byte(8'h02);
    send_byte(a[15:8]);
    send_byte(a[7:0]);
    for (int i = 0; i < n; i++) send_byte(wbuf[i]);
    for (int i = 0; i < tail_bits; i++) begin
      logic r, oe;
      bit_x(1'b1, r, oe);
    end
    end_x();
  endtask

  task automatic read_chk(input logic [15:0] a, input int n, input int hold_byte, input string req);
    logic [7:0] v;
    logic oe;
    int idx;
    begin_x();
    send_byte(8'h03);
    send_byte(a[15:8]);
    send_byte(a[7:0]);
    for (int i = 0; i < n; i++) begin
      idx = (int'(a) + i) % DEPTH;
      recv_byte(v, oe, (i == hold_byte) ? 3 : -1);
      chk(v == mdl[idx] && oe, req, {oe, v}, {1'b1, mdl[idx]});
      if (i == hold_byte) chk(hold_oe == 1'b0, "R11 hold oe", hold_oe, 0);
    end
    end_x();
  endtask

  task automatic stat_chk(input logic [7:0] exp, input string req);
    logic [7:0] v;
    rdsr(v);
    chk(v == exp, req, v, exp);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic oe, r;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    // R10 R12: reset state
    chk(spi_so_oe == 1'b0, "R10 reset oe", spi_so_oe, 0);
    stat_chk(8'h00, "R12 reset status");

    // R8: set, clear, cancelled by an extra clock
    cmd(8'h06);
    stat_chk(8'h02, "R8 wren sets latch");
    cmd(8'h04);
    stat_chk(8'h00, "R8 wrdi clears latch");
    begin_x(); send_byte(8'h06); bit_x(1'b0, r, oe); end_x();
    stat_chk(8'h00, "R8 wren with extra clock");

    // R2 R4: fill every page, mode 0
    for (int p = 0; p < DEPTH / PAGE; p++) begin
      for (int i = 0; i < PAGE; i++) begin
        wbuf[i] = pat(p * PAGE + i);
        mdl[p * PAGE + i] = wbuf[i];
      end
      cmd(8'h06);
      write_mem(16'(p * PAGE), PAGE, 0);
      tick(WC + 20);
    end
    // R2 R5: full sweep
    read_chk(16'h0000, DEPTH, -1, "R2 R5 sweep mode0");

    // R3 R5 R2: upper address bits ignored, top wrap, mode 3
    mode3 = 1'b1;
    read_chk(16'hA5F8, 16, -1, "R3 R5 wrap mode3");
    mode3 = 1'b0;

    // R4: page overflow wraps inside page 5
    for (int i = 0; i < 36; i++) begin
      wbuf[i] = 8'(8'h80 + i);
      mdl[5 * PAGE + ((30 + i) % PAGE)] = wbuf[i];
    end
    cmd(8'h06);
    write_mem(16'(5 * PAGE + 30), 36, 0);
    tick(WC + 20);
    read_chk(16'(5 * PAGE), PAGE, -1, "R4 page wrap");

    // R8: write without latch ignored
    wbuf[0] = 8'h11;
    write_mem(16'h0030, 1, 0);
    tick(WC + 20);
    read_chk(16'h0030, 1, -1, "R8 no latch write");

    // R6: partial byte, and no data byte, abort
    cmd(8'h06);
    wbuf[0] = 8'h22;
    write_mem(16'h0031, 1, 4);
    stat_chk(8'h02, "R6 partial keeps latch no cycle");
    write_mem(16'h0032, 0, 0);
    stat_chk(8'h02, "R6 empty keeps latch no cycle");
    read_chk(16'h0031, 2, -1, "R6 abort leaves memory");

    // R7 R9: busy window
    wbuf[0] = 8'h5A;
    mdl[16'h0040] = 8'h5A;
    write_mem(16'h0040, 1, 0);
    stat_chk(8'h03, "R7 status during cycle");
    begin_x();
    send_byte(8'h03);
    for (int i = 0; i < 24; i++) begin
      bit_x(1'b0, r, oe);
      chk(oe == 1'b0, "R7 read ignored while busy", oe, 0);
    end
    end_x();
    tick(WC);
    stat_chk(8'h00, "R9 latch cleared after cycle");

    // R11: pause in the middle of a byte
    read_chk(16'h003E, 4, 1, "R11 hold resume");

    // R1: unknown instruction keeps output off
    begin_x();
    send_byte(8'h9F);
    for (int i = 0; i < 16; i++) begin
      bit_x(1'b0, r, oe);
      chk(oe == 1'b0, "R1 unknown opcode", oe, 0);
    end
    end_x();

    // R12 R9: status write mask
    cmd(8'h06);
    begin_x(); send_byte(8'h01); send_byte(8'hFF); end_x();
    tick(WC + 20);
    stat_chk(8'hDC, "R12 status write");
    cmd(8'h06);
    begin_x(); send_byte(8'h01); send_byte(8'h00); end_x();
    tick(WC + 20);
    stat_chk(8'h00, "R12 status clear");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule